// File: doc/BRIEF.md
# Quadword Add/Subtract Unit

This unit adds or subtracts two 128-bit unsigned operands and returns either the 128-bit wrapped result or only the final carry. It covers eight operations on one adder: add or subtract, each in a plain form or an extended form, and each returning either the modulo result or the carry. Subtraction is A plus the bitwise complement of B plus a carry-in. The plain subtract forms use a carry-in of 1 and the plain add forms use a carry-in of 0. The extended forms take their carry-in from bit 0 of a third operand C.

The sum is built from four chained 32-bit slices. The carry-in enters the lowest slice and each slice's carry feeds the slice above it. The operation comes from an 11-bit minor-opcode field. The four full 11-bit codes are matched first. If none of them matches, the low 6 bits of the field select an extended form. Any other code is illegal: it raises a flag and gives a zero result.

The datapath is combinational. One register stage sits at the output, so each result appears on the cycle after its operands are presented.

Top module: `qadd_unit`

## Requirements
- R1: Opcode 0x100 returns (A + B) mod 2^128.
- R2: Opcode 0x140 returns the carry out of A + B in bit 0, with bits 127:1 zero.
- R3: Opcode 0x500 returns (A + ~B + 1) mod 2^128, that is A - B wrapped.
- R4: Opcode 0x540 returns the carry out of A + ~B + 1 in bit 0 (1 exactly when A >= B), with bits 127:1 zero.
- R5: When the low 6 bits of the opcode are 0x3C, 0x3D, 0x3E or 0x3F, the unit performs extended add modulo, extended add carry, extended subtract modulo or extended subtract carry respectively. The carry-in is C[0] in place of the constant, and bits 127:1 of C have no effect on the result.
- R6: The four 11-bit codes of R1 to R4 take priority. Any other opcode whose low 6 bits are 0x3C to 0x3F is an extended form, whatever its upper 5 bits hold.
- R7: Any opcode not covered by R1 to R6 sets out_illegal to 1 and gives an out_result of zero. A legal opcode gives out_illegal 0.
- R8: Carries ripple correctly across all four 32-bit slices, including a slice whose addend is all ones and whose incoming carry is 1 (for example A - 0 or A + ~0 + 1). The result always equals the low 128 bits of the true 129-bit sum, and the carry forms return bit 128 of that sum.
- R9: out_valid is 1 on exactly the cycle after each cycle in which in_valid is 1. out_result and out_illegal keep their values while in_valid is 0. After reset, out_valid, out_result and out_illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| in_op | input | 11 | Minor-opcode field that selects the operation |
| in_a | input | 128 | Operand A |
| in_b | input | 128 | Operand B (complemented for subtract) |
| in_c | input | 128 | Operand C; only bit 0 is used, as the carry-in of the extended forms |
| out_valid | output | 1 | out_result and out_illegal hold a new result |
| out_result | output | 128 | Modulo result, or the carry zero-extended to 128 bits |
| out_illegal | output | 1 | The opcode was not recognised |

## Verification
The bench aims at subtracting zero and adding an all-ones addend with a carry-in of 1. In that case a slice sum equals its A input while a carry still comes out. A design that detects carries with a less-than compare drops that carry and returns A minus 2^32 (or worse) in place of A. Carry chains that cross every slice boundary, the A = B and A < B subtract cases, and extended forms whose C has bit 0 clear and every other bit set are also driven. A design that used more of C than bit 0, or that kept the constant carry-in for the extended subtract forms, gives a result that is off by one. Opcodes such as 0x7FC and 0x7FF exercise the extended decode on the low 6 bits, while 0x54C, 0x03B and 0x000 must come back illegal with a zero result. Gaps between inputs check that the registered outputs hold their values.

// File: rtl/qadd_pkg.sv
package qadd_pkg;

  localparam int OPC_W = 11;
  localparam int EXT_W = 6;

  // full-width minor codes, matched first
  localparam logic [OPC_W-1:0] OPC_ADD_MOD = 11'h100;
  localparam logic [OPC_W-1:0] OPC_ADD_CRY = 11'h140;
  localparam logic [OPC_W-1:0] OPC_SUB_MOD = 11'h500;
  localparam logic [OPC_W-1:0] OPC_SUB_CRY = 11'h540;

  // short codes, matched on the low bits only when no full code hits
  localparam logic [EXT_W-1:0] EXT_ADD_MOD = 6'h3C;
  localparam logic [EXT_W-1:0] EXT_ADD_CRY = 6'h3D;
  localparam logic [EXT_W-1:0] EXT_SUB_MOD = 6'h3E;
  localparam logic [EXT_W-1:0] EXT_SUB_CRY = 6'h3F;

  typedef struct packed {
    logic legal;       // opcode recognised
    logic sub;         // complement B
    logic carry_only;  // return carry instead of sum
    logic ext;         // carry-in comes from operand C
  } qop_t;

  function automatic qop_t qop_decode(input logic [OPC_W-1:0] op);
    qop_t d;
    d = '0;
    case (op)
      OPC_ADD_MOD: begin d.legal = 1'b1; end
      OPC_ADD_CRY: begin d.legal = 1'b1; d.carry_only = 1'b1; end
      OPC_SUB_MOD: begin d.legal = 1'b1; d.sub = 1'b1; end
      OPC_SUB_CRY: begin d.legal = 1'b1; d.sub = 1'b1; d.carry_only = 1'b1; end
      default: begin
        case (op[EXT_W-1:0])
          EXT_ADD_MOD: begin d.legal = 1'b1; d.ext = 1'b1; end
          EXT_ADD_CRY: begin d.legal = 1'b1; d.ext = 1'b1; d.carry_only = 1'b1; end
          EXT_SUB_MOD: begin d.legal = 1'b1; d.ext = 1'b1; d.sub = 1'b1; end
          EXT_SUB_CRY: begin
            d.legal = 1'b1; d.ext = 1'b1; d.sub = 1'b1; d.carry_only = 1'b1;
          end
          default: d = '0;
        endcase
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/qadd_decode.sv
module qadd_decode
  import qadd_pkg::*;
(
  input  logic [OPC_W-1:0] op_field,
  output qop_t             dec
);

  assign dec = qop_decode(op_field);

  always_comb begin
    // R7: an unrecognised code must not steer the datapath
    if (!dec.legal)
      p_illegal_clear_r7: assert (!dec.sub && !dec.carry_only && !dec.ext);
    // R6: a short-code hit never shadows a full-code match
    if (dec.ext)
      p_full_first_r6: assert (op_field != OPC_ADD_MOD && op_field != OPC_ADD_CRY &&
                               op_field != OPC_SUB_MOD && op_field != OPC_SUB_CRY);
  end

endmodule

// File: rtl/qadd_slice.sv
module qadd_slice #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic logic [W:0] slice_add(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  logic [W:0] wide;
  logic       wrapped_below_a;  // sum fell under a: the compare-style carry
  logic       wrapped_to_a;     // full wrap: addend all ones plus carry-in

  assign wide            = slice_add(a, b, cin);
  assign sum             = wide[W-1:0];
  assign cout            = wide[W];
  assign wrapped_below_a = (sum < a);
  assign wrapped_to_a    = (&b) && cin;

  always_comb begin
    // R8: a compare-detected wrap always shows up as a carry
    if (wrapped_below_a)
      p_wrap_carry_r8: assert (cout);
    // R8: the only carry the compare misses is the all-ones plus carry case
    if (cout && !wrapped_below_a)
      p_full_wrap_r8: assert (wrapped_to_a && sum == a);
  end

endmodule

// File: rtl/qadd_chain.sv
module qadd_chain #(
  parameter int SLICE_W    = 32,
  parameter int NUM_SLICES = 4
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] a,
  input  logic [SLICE_W*NUM_SLICES-1:0] b,
  input  logic                          cin,
  output logic [SLICE_W*NUM_SLICES-1:0] sum,
  output logic                          cout
);

  localparam int DATA_W = SLICE_W * NUM_SLICES;

  logic [NUM_SLICES:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    qadd_slice #(.W(SLICE_W)) u_slice (
      .a   (a[i*SLICE_W +: SLICE_W]),
      .b   (b[i*SLICE_W +: SLICE_W]),
      .cin (carry[i]),
      .sum (sum[i*SLICE_W +: SLICE_W]),
      .cout(carry[i+1])
    );
  end

  assign cout = carry[NUM_SLICES];

  // R8: the whole chain matches one wide addition
  always_comb begin
    p_chain_sum_r8: assert ({cout, sum} ==
                            ({1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin}));
  end

endmodule

// File: rtl/qadd_unit.sv
module qadd_unit
  import qadd_pkg::*;
#(
  parameter int SLICE_W    = 32,
  parameter int NUM_SLICES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [OPC_W-1:0]              in_op,
  input  logic [SLICE_W*NUM_SLICES-1:0] in_a,
  input  logic [SLICE_W*NUM_SLICES-1:0] in_b,
  input  logic [SLICE_W*NUM_SLICES-1:0] in_c,
  output logic                          out_valid,
  output logic [SLICE_W*NUM_SLICES-1:0] out_result,
  output logic                          out_illegal
);

  localparam int DATA_W = SLICE_W * NUM_SLICES;

  qop_t              dec;
  logic [DATA_W-1:0] addend_b;
  logic [DATA_W-1:0] chain_sum;
  logic              chain_cin;
  logic              chain_cout;
  logic [DATA_W-1:0] next_result;
  logic              carry_form_q;  // registered: last result was a carry form

  qadd_decode u_dec (
    .op_field(in_op),
    .dec     (dec)
  );

  assign addend_b  = dec.sub ? ~in_b : in_b;
  assign chain_cin = dec.ext ? in_c[0] : dec.sub;

  qadd_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chain (
    .a   (in_a),
    .b   (addend_b),
    .cin (chain_cin),
    .sum (chain_sum),
    .cout(chain_cout)
  );

  always_comb begin
    if (!dec.legal)          next_result = '0;
    else if (dec.carry_only) next_result = DATA_W'(chain_cout);
    else                     next_result = chain_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_illegal  <= 1'b0;
      carry_form_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= next_result;
        out_illegal  <= !dec.legal;
        carry_form_q <= dec.legal && dec.carry_only;
      end
    end
  end

  // R3, R5: carry-in selection per form
  always_comb begin
    if (dec.legal && !dec.ext)
      p_plain_cin_r3: assert (chain_cin == dec.sub);
    if (dec.ext)
      p_ext_cin_r5: assert (chain_cin == in_c[0]);
  end

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  p_carry_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && carry_form_q) |-> (out_result[DATA_W-1:1] == '0));

endmodule

// File: tb/tb_qadd_unit.sv
module tb_qadd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [10:0]   in_op = '0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic          out_valid;
  logic [DW-1:0] out_result;
  logic          out_illegal;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [DW-1:0] q_res[$];
  logic          q_ill[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qadd_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  // reference: a 129-bit sum taken straight from the requirements
  function automatic void model(input logic [10:0] op, input logic [DW-1:0] a,
                                input logic [DW-1:0] b, input logic [DW-1:0] c,
                                output logic [DW-1:0] res, output logic ill);
    logic known, neg, only_c, from_c;
    logic [DW:0] total;
    known = 1; neg = 0; only_c = 0; from_c = 0;
    if (op == 11'h100)      begin end
    else if (op == 11'h140) only_c = 1;
    else if (op == 11'h500) neg = 1;
    else if (op == 11'h540) begin neg = 1; only_c = 1; end
    else if (op[5:0] == 6'h3C) from_c = 1;
    else if (op[5:0] == 6'h3D) begin from_c = 1; only_c = 1; end
    else if (op[5:0] == 6'h3E) begin from_c = 1; neg = 1; end
    else if (op[5:0] == 6'h3F) begin from_c = 1; neg = 1; only_c = 1; end
    else known = 0;
    total = {1'b0, a} + {1'b0, (neg ? ~b : b)} +
            (DW+1)'(from_c ? c[0] : neg);
    ill = !known;
    if (!known)      res = '0;
    else if (only_c) res = DW'(total[DW]);
    else             res = total[DW-1:0];
  endfunction

  task automatic note(input bit ok, input string tag,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] op, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [DW-1:0] c,
                       input string tag);
    logic [DW-1:0] r;
    logic          il;
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_c = c; in_valid = 1'b1;
    model(op, a, b, c, r, il);
    q_res.push_back(r); q_ill.push_back(il); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item per out_valid
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (q_res.size() == 0) begin
          note(1'b0, "R9 spurious valid", DW'(out_valid), '0);
        end else begin
          logic [DW-1:0] er;
          logic          ei;
          string         et;
          er = q_res.pop_front(); ei = q_ill.pop_front(); et = q_tag.pop_front();
          note(out_result == er, {et, " result"}, out_result, er);
          note(out_illegal == ei, {et, " illegal"}, DW'(out_illegal), DW'(ei));
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ZERO = '0;

  initial begin
    logic [DW-1:0] hold_r;
    logic          hold_i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    note(out_valid == 1'b0, "R9 reset valid", DW'(out_valid), '0);
    note(out_result == '0, "R9 reset result", out_result, '0);
    note(out_illegal == 1'b0, "R9 reset illegal", DW'(out_illegal), '0);

    // R1 add modulo
    drive(11'h100, 128'd5, 128'd7, ZERO, "R1 small add");
    drive(11'h100, ONES, 128'd1, ZERO, "R1 full wrap");
    drive(11'h100, 128'h0000_0000_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'd1, ZERO, "R1 three-slice carry");
    // R2 add carry
    drive(11'h140, ONES, 128'd1, ZERO, "R2 carry set");
    drive(11'h140, ONES, ZERO, ONES, "R2 carry clear");
    // R3 subtract modulo, including the all-ones ripple trap (R8)
    drive(11'h500, 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, ZERO, ZERO, "R3 R8 minus zero");
    drive(11'h500, ZERO, 128'd1, ZERO, "R3 zero minus one");
    drive(11'h500, 128'd100, 128'd100, ZERO, "R3 equal");
    // R4 subtract carry
    drive(11'h540, 128'd100, 128'd100, ZERO, "R4 equal");
    drive(11'h540, 128'd99, 128'd100, ZERO, "R4 less");
    drive(11'h540, ONES, ZERO, ZERO, "R4 R8 minus zero");
    // R5 extended forms, C upper bits toggled
    drive(11'h03C, ONES, ZERO, 128'd1, "R5 ext add cin1");
    drive(11'h03C, ONES, ZERO, ~128'd1, "R5 ext add C upper ignored");
    drive(11'h03D, ONES, ZERO, 128'd1, "R5 ext add carry");
    drive(11'h03E, 128'd50, 128'd20, ZERO, "R5 ext sub cin0");
    drive(11'h03E, 128'd50, 128'd20, ONES, "R5 ext sub cin1");
    drive(11'h03F, 128'd20, 128'd20, ~128'd1, "R5 ext sub carry cin0");
    drive(11'h03F, 128'd20, ZERO, 128'd1, "R5 R8 ext sub carry trap");
    // R6 priority and upper-bit don't-care
    drive(11'h7FC, 128'd3, 128'd4, 128'd1, "R6 upper bits ext add");
    drive(11'h7FF, 128'd3, 128'd4, ZERO, "R6 upper bits ext sub carry");
    drive(11'h43D, ONES, ONES, ZERO, "R6 mixed upper ext carry");
    // R7 illegal
    drive(11'h54C, ONES, ONES, ONES, "R7 unhandled code");
    drive(11'h000, 128'd1, 128'd1, ZERO, "R7 zero code");
    drive(11'h03B, 128'd1, 128'd1, ZERO, "R7 neighbour short code");
    drive(11'h101, 128'd1, 128'd1, ZERO, "R7 neighbour full code");

    // R9 hold across a gap
    drive(11'h100, 128'hDEAD, 128'hBEEF, ZERO, "R9 pre-gap");
    model(11'h100, 128'hDEAD, 128'hBEEF, ZERO, hold_r, hold_i);
    idle(4);
    #1;
    note(out_result == hold_r, "R9 hold result", out_result, hold_r);
    note(out_valid == 1'b0, "R9 idle valid", DW'(out_valid), '0);

    // R8 random slice-boundary patterns
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] ra, rb, rc;
      logic [10:0]   rop;
      int            k;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rc = {$urandom, $urandom, $urandom, $urandom};
      k = $urandom_range(0, 9);
      if (k == 0) ra[63:0] = '1;
      if (k == 1) rb = '0;
      if (k == 2) rb = ra;
      case ($urandom_range(0, 8))
        0: rop = 11'h100;
        1: rop = 11'h140;
        2: rop = 11'h500;
        3: rop = 11'h540;
        4, 5: rop = {5'($urandom), 4'hF, 2'($urandom)};
        default: rop = 11'($urandom);
      endcase
      drive(rop, ra, rb, rc, "R8 random");
      if ($urandom_range(0, 7) == 0) idle(1);
    end

    idle(3);
    #1;
    note(q_res.size() == 0, "R9 drained", DW'(q_res.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule